// File: doc/BRIEF.md
# Aligned Dual-Ratio Clock Divider

This block takes one input clock and produces two groups of divided clocks. Group A runs at one half or one quarter of the input rate. Group B runs at one quarter or one sixth of the input rate. Each group has its own ratio select. Every output is a registered decode of a single shared phase counter. As a result, edges that fall at the same instant in both groups always come from the same rising input edge. Each group drives several identical copies of its clock, so that fanout can be spread.

A common enable is captured on the falling input edge. When the enable drops, counting continues until every selected output is low, and only then does the phase freeze. No high pulse is ever cut short. While frozen, all outputs stay low. When the enable returns, counting resumes from the frozen phase. A ratio change is applied only at phase 0, where all outputs are low. An asynchronous, active-high master reset forces phase 0 with all outputs low, so that several instances can be started in step.

Top module: `dual_ratio_divider`

## Requirements
- R1: With `selA`=0 every `clkA` copy toggles at half the input rate. With `selA`=1 it is high for 2 input cycles and low for 2.
- R2: With `selB`=0 every `clkB` copy is high for 2 input cycles and low for 2. With `selB`=1 it is high for 3 and low for 3.
- R3: Both groups decode one phase p that steps 0..11 and wraps to 0. A group with ratio r is high exactly when (p mod r) >= r/2. Phase 0 therefore has all outputs low, and coinciding edges of both groups share one rising edge.
- R4: `enable` is sampled only on the falling input edge. A pulse that begins after one falling edge and ends before the next has no effect.
- R5: While the sampled enable is low, the phase still advances on each rising edge on which any selected output is high. It freezes once all outputs are low. No high level is shortened.
- R6: While frozen, all outputs are low. After re-enable, counting resumes from the frozen phase.
- R7: A new value on `selA` or `selB` is taken only on a rising edge at which the phase is 0. That edge already uses the new ratio.
- R8: `mrst` high immediately forces all outputs low and the phase to 0. It also clears the sampled enable and the active selects.
- R9: All copies within a group are identical at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| enable | input | 1 | Common enable, sampled on the falling edge of clkIn |
| selA | input | 1 | Group A ratio: 0 divides by 2, 1 divides by 4 |
| selB | input | 1 | Group B ratio: 0 divides by 4, 1 divides by 6 |
| clkA | output | NUM_A | Group A divided clock copies |
| clkB | output | NUM_B | Group B divided clock copies |

## Verification
All four select combinations run continuously for several full 12-phase periods. This separates the group ratios and checks that the shared phase stays aligned. The enable is dropped once at each of the twelve phases, which shows whether a freeze waits for the selected outputs to go low and whether resume starts from the held phase. A short enable pulse placed between two falling edges separates falling-edge sampling from rising-edge sampling. Select changes at every phase show whether the new ratio waits for phase 0. A reset asserted mid-cycle shows whether the outputs clear without waiting for a clock edge.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef struct packed {
    logic step;     // advance the shared phase this rising edge
    logic loadSel;  // capture ratio selects (phase wrap point)
  } divStrobeT;

  function automatic int gcdF(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    for (int i = 0; i < 64; i++) begin
      if (y != 0) begin
        t = x % y;
        x = y;
        y = t;
      end
    end
    return x;
  endfunction

  function automatic int lcmF(input int a, input int b);
    return (a / gcdF(a, b)) * b;
  endfunction

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [PW-1:0] phase,
  input  logic          curA,
  input  logic          curB,
  output divStrobeT     strobe
);

  logic enNeg;

  // enable captured on the falling edge only
  always_ff @(negedge clk or posedge rst) begin
    if (rst) enNeg <= 1'b0;
    else     enNeg <= enable;
  end

  // keep stepping while any selected output is high so nothing is truncated
  always_comb begin
    strobe.step    = enNeg | curA | curB;
    strobe.loadSel = (phase == '0);
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int A_LO  = 2,
  parameter int A_HI  = 4,
  parameter int B_LO  = 4,
  parameter int B_HI  = 6,
  parameter int NUM_A = 2,
  parameter int NUM_B = 2,
  parameter int MODV  = 12,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobeT        strobe,
  input  logic             selA,
  input  logic             selB,
  output logic [PW-1:0]    phase,
  output logic [NUM_A-1:0] clkA,
  output logic [NUM_B-1:0] clkB
);

  logic          selActA;
  logic          selActB;
  logic          selUseA;
  logic          selUseB;
  logic [PW-1:0] nxt;
  logic          hiA;
  logic          hiB;
  int            nxtI;

  always_comb begin
    selUseA = strobe.loadSel ? selA : selActA;
    selUseB = strobe.loadSel ? selB : selActB;
    if (!strobe.step)                 nxt = phase;
    else if (phase == PW'(MODV - 1))  nxt = '0;
    else                              nxt = phase + 1'b1;
    nxtI = int'(nxt);
    hiA = selUseA ? ((nxtI % A_HI) >= (A_HI / 2)) : ((nxtI % A_LO) >= (A_LO / 2));
    hiB = selUseB ? ((nxtI % B_HI) >= (B_HI / 2)) : ((nxtI % B_LO) >= (B_LO / 2));
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase   <= '0;
      selActA <= 1'b0;
      selActB <= 1'b0;
    end else begin
      phase <= nxt;
      if (strobe.loadSel) begin
        selActA <= selA;
        selActB <= selB;
      end
    end
  end

  for (genvar i = 0; i < NUM_A; i++) begin : gCopyA
    always_ff @(posedge clk or posedge rst) begin
      if (rst) clkA[i] <= 1'b0;
      else     clkA[i] <= hiA;
    end
  end

  for (genvar j = 0; j < NUM_B; j++) begin : gCopyB
    always_ff @(posedge clk or posedge rst) begin
      if (rst) clkB[j] <= 1'b0;
      else     clkB[j] <= hiB;
    end
  end

endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
  import div_pkg::*;
#(
  parameter int A_LO  = 2,
  parameter int A_HI  = 4,
  parameter int B_LO  = 4,
  parameter int B_HI  = 6,
  parameter int NUM_A = 2,
  parameter int NUM_B = 2
) (
  input  logic             clkIn,
  input  logic             mrst,
  input  logic             enable,
  input  logic             selA,
  input  logic             selB,
  output logic [NUM_A-1:0] clkA,
  output logic [NUM_B-1:0] clkB
);

  localparam int MODV = lcmF(lcmF(A_LO, A_HI), lcmF(B_LO, B_HI));
  localparam int PW   = $clog2(MODV);

  divStrobeT     strobe;
  logic [PW-1:0] phase;

  div_ctrl #(.PW(PW)) uCtrl (
    .clk    (clkIn),
    .rst    (mrst),
    .enable (enable),
    .phase  (phase),
    .curA   (clkA[0]),
    .curB   (clkB[0]),
    .strobe (strobe)
  );

  div_datapath #(
    .A_LO(A_LO), .A_HI(A_HI), .B_LO(B_LO), .B_HI(B_HI),
    .NUM_A(NUM_A), .NUM_B(NUM_B), .MODV(MODV), .PW(PW)
  ) uData (
    .clk    (clkIn),
    .rst    (mrst),
    .strobe (strobe),
    .selA   (selA),
    .selB   (selB),
    .phase  (phase),
    .clkA   (clkA),
    .clkB   (clkB)
  );

endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int NUM_A = 2,
  parameter int NUM_B = 2,
  parameter int MODV  = 12,
  parameter int PW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [PW-1:0]    phase,
  input logic [NUM_A-1:0] clkA,
  input logic [NUM_B-1:0] clkB
);

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |-> (clkA == '0 && clkB == '0 && phase == '0)); // R8

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase) |-> (phase == (($past(phase) == PW'(MODV - 1)) ? '0 : $past(phase) + 1'b1))); // R3

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |-> (clkA == '0 && clkB == '0)); // R7

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    (clkA[0] || clkB[0]) |=> (phase != $past(phase))); // R5

  AST_FROZEN_LOW: assert property (@(posedge clk) disable iff (rst)
    $stable(phase) |-> (clkA == '0 && clkB == '0)); // R6

  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (rst)
    (clkA == {NUM_A{clkA[0]}}) && (clkB == {NUM_B{clkB[0]}})); // R9

endmodule

bind dual_ratio_divider div_checker #(
  .NUM_A(NUM_A), .NUM_B(NUM_B), .MODV(MODV), .PW(PW)
) uChk (
  .clk   (clkIn),
  .rst   (mrst),
  .phase (phase),
  .clkA  (clkA),
  .clkB  (clkB)
);

// File: tb/tb_dual_ratio_divider.sv
module tb_dual_ratio_divider;

  localparam int NA = 2;
  localparam int NB = 2;

  logic clkIn = 1'b0;
  logic mrst = 1'b1;
  logic enable = 1'b0;
  logic selA = 1'b0;
  logic selB = 1'b0;
  logic [NA-1:0] clkA;
  logic [NB-1:0] clkB;

  int total = 0;
  int bad = 0;
  logic checking = 1'b0;
  string curTag = "R1";
  logic finished = 1'b0;

  always #4 clkIn = ~clkIn;  // 125 MHz

  dual_ratio_divider #(.NUM_A(NA), .NUM_B(NB)) dut (
    .clkIn(clkIn), .mrst(mrst), .enable(enable),
    .selA(selA), .selB(selB), .clkA(clkA), .clkB(clkB)
  );

  // reference behaviour, computed from the requirements
  int   refPh;
  logic refSa, refSb, refEn, expA, expB;

  always @(negedge clkIn or posedge mrst) begin
    if (mrst) refEn <= 1'b0;
    else      refEn <= enable;
  end

  always @(posedge clkIn or posedge mrst) begin
    if (mrst) begin
      refPh <= 0; refSa <= 1'b0; refSb <= 1'b0; expA <= 1'b0; expB <= 1'b0;
    end else begin
      logic ua, ub;
      int ra, rb, np;
      ua = (refPh == 0) ? selA : refSa;
      ub = (refPh == 0) ? selB : refSb;
      ra = ua ? 4 : 2;
      rb = ub ? 6 : 4;
      np = (refEn || expA || expB) ? (refPh + 1) % 12 : refPh;
      if (refPh == 0) begin refSa <= selA; refSb <= selB; end
      refPh <= np;
      expA  <= (np % ra) >= ra / 2;
      expB  <= (np % rb) >= rb / 2;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clkIn) begin
    if (!mrst && checking) begin
      chk(clkA[0] == expA, {curTag, " clkA"}, clkA[0], expA);
      chk(clkB[0] == expB, {curTag, " clkB"}, clkB[0], expB);
      chk(clkA == {NA{clkA[0]}} && clkB == {NB{clkB[0]}}, "R9 copies",
          int'({clkA, clkB}), int'({{NA{clkA[0]}}, {NB{clkB[0]}}}));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clkIn);
    #2;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(clkA == '0 && clkB == '0, "R8 reset state", int'({clkA, clkB}), 0);
    mrst = 1'b0;
    enable = 1'b1;
    checking = 1'b1;

    // all ratio combinations, free running
    for (int s = 0; s < 4; s++) begin
      curTag = (s % 2 == 0) ? "R1 R3" : "R2 R3";
      selA = s[0];
      selB = s[1];
      cyc(40);
    end

    // disable at every phase, then resume
    for (int sa = 0; sa < 2; sa++) begin
      selA = sa[0]; selB = ~sa[0];
      cyc(24);
      for (int k = 0; k < 12; k++) begin
        curTag = "R5";
        cyc(k + 1);
        enable = 1'b0;
        cyc(9);
        chk(clkA == '0 && clkB == '0, "R6 frozen low", int'({clkA, clkB}), 0);
        curTag = "R6";
        enable = 1'b1;
        cyc(13);
      end
    end

    // enable pulse fully between two falling edges
    curTag = "R4";
    enable = 1'b0;
    cyc(10);
    for (int k = 0; k < 4; k++) begin
      @(negedge clkIn); #1 enable = 1'b1;
      @(posedge clkIn); #1 enable = 1'b0;
      cyc(6);
      chk(clkA == '0 && clkB == '0, "R4 short pulse ignored", int'({clkA, clkB}), 0);
    end
    enable = 1'b1;
    cyc(20);

    // select changes at every phase
    curTag = "R7";
    for (int k = 0; k < 24; k++) begin
      selA = ~selA;
      if (k % 3 == 0) selB = ~selB;
      cyc(k % 12 + 1);
    end
    cyc(30);

    // asynchronous reset mid-cycle
    curTag = "R8";
    @(posedge clkIn); #1;
    mrst = 1'b1;
    #1;
    chk(clkA == '0 && clkB == '0, "R8 async clear", int'({clkA, clkB}), 0);
    cyc(2);
    mrst = 1'b0;
    selA = 1'b1; selB = 1'b1;
    curTag = "R3 R8";
    cyc(36);

    checking = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule